// File: doc/BRIEF.md
# Byte FIFO with Fill-Level Flags

This block is a twelve-entry byte queue placed between a host register port and a transmit/receive engine. A direction input sets which side fills the queue. In transmit direction the host writes bytes and the engine takes them. In receive direction the engine deposits bytes and the host reads them out. The storage is circular, so a frame longer than twelve bytes can stream through, provided the host keeps up.

A status byte gives the fill level as the stored count minus one, a sticky overflow bit and two level bits. The low-level bit is used while transmitting and the high-level bit while receiving. An interrupt line is raised when the queue is nearly drained during transmit, or nearly full during receive, so that the host can service it in time. A single-cycle clear command empties the queue and drops the overflow record.

Top module: `byte_level_fifo`

## Requirements
- R1: After reset the queue holds no bytes: `status` is 0x00, `irq` is low and `rd_data` is 0x00 while `dir_tx` is 0.
- R2: Bytes leave in the order they were accepted. The storage wraps around its 12 slots without loss, and `rd_data` shows the oldest stored byte.
- R3: `status[3:0]` equals the stored count minus one when at least one byte is held, and reads 0 when the queue is empty.
- R4: A push while 12 bytes are held, with no accepted pop in the same cycle, is dropped and sets `status[4]`. That bit then stays at 1 until a clear command.
- R5: A pop while the queue is empty is ignored. `rd_data` reads 0x00 whenever the queue is empty.
- R6: A push and a pop accepted in the same cycle leave the count unchanged, including when the queue is full.
- R7: `status[5]` is 1 exactly when `dir_tx` is 1 and at most 3 bytes are held.
- R8: `status[6]` is 1 exactly when `dir_tx` is 0 and at least 9 bytes are held.
- R9: `irq` is 1 exactly when (`dir_tx` is 1 and fewer than 3 bytes are held) or (`dir_tx` is 0 and more than 9 bytes are held).
- R10: `clear_cmd` empties the queue and clears `status[4]` at the next edge. It takes priority over any push or pop in the same cycle.
- R11: With `dir_tx` at 1, pushes come from `host_wr_en`/`host_wr_data` and pops from `eng_rd_en`, while `host_rd_en` and `eng_wr_en` have no effect. With `dir_tx` at 0, pushes come from `eng_wr_en`/`eng_wr_data` and pops from `host_rd_en`, and the other two are ignored.
- R12: `status[7]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_tx | input | 1 | 1 = transmit direction, 0 = receive direction |
| clear_cmd | input | 1 | One-cycle command that empties the queue |
| host_wr_en | input | 1 | Host write strobe (used in transmit direction) |
| host_wr_data | input | 8 | Host write byte |
| host_rd_en | input | 1 | Host read strobe (used in receive direction) |
| eng_wr_en | input | 1 | Engine write strobe (used in receive direction) |
| eng_wr_data | input | 8 | Engine write byte |
| eng_rd_en | input | 1 | Engine take strobe (used in transmit direction) |
| rd_data | output | 8 | Oldest stored byte, or 0x00 when empty |
| status | output | 8 | {0, high, low, overflow, count-minus-one} |
| irq | output | 1 | Level service request |

## Verification
The assertions assume that reset is applied before the first checked edge and that `dir_tx` may change in any cycle. They also assume that strobes can be raised toward either side at any time, including toward a full or an empty queue. The assertions do not assume that a caller avoids overflow, so the drop and sticky-flag properties are exercised directly. The stimulus alternates between fill-biased and drain-biased phases of random strobes, with both directions and occasional clears. This drives the count across both thresholds and into the full and empty limits, while directed steps cover the simultaneous full push/pop, the clear-with-push collision and the strobes that must be ignored.

// File: rtl/bytefifo_pkg.sv
package bytefifo_pkg;

  // Advance a ring index, wrapping after the last slot.
  function automatic int unsigned ring_next(input int unsigned idx,
                                            input int unsigned slots);
    return (idx == slots - 1) ? 0 : idx + 1;
  endfunction

  // Fill field of the status byte: held count minus one, floored at zero.
  function automatic logic [3:0] fill_code(input logic [7:0] held);
    return (held == 8'd0) ? 4'd0 : 4'(held - 8'd1);
  endfunction

  // Low-water test used while transmitting.
  function automatic logic at_or_below(input logic [7:0] held,
                                       input logic [7:0] mark);
    return held <= mark;
  endfunction

  // High-water test used while receiving.
  function automatic logic at_or_above(input logic [7:0] held,
                                       input logic [7:0] mark);
    return held >= mark;
  endfunction

endpackage

// File: rtl/bytefifo_store.sv
module bytefifo_store #(
  parameter int DEPTH = 12,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] head_data
);
  import bytefifo_pkg::*;

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [PTR_W-1:0] wr_ptr_nx;
  logic [PTR_W-1:0] rd_ptr_nx;

  assign wr_ptr_nx = PTR_W'(ring_next(32'(wr_ptr), DEPTH));
  assign rd_ptr_nx = PTR_W'(ring_next(32'(rd_ptr), DEPTH));

  always_ff @(posedge clk) begin
    if (push && !clear) slots[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr_nx;
      if (pop)  rd_ptr <= rd_ptr_nx;
    end
  end

  assign head_data = slots[rd_ptr];

endmodule

// File: rtl/bytefifo_level.sv
module bytefifo_level #(
  parameter int DEPTH = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             drop,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  assign pop_ok  = pop_req && (count != '0);
  assign push_ok = push_req && ((count != FULL_C) || pop_ok);
  assign drop    = push_req && !push_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else if (clear) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (drop) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/bytefifo_flags.sv
module bytefifo_flags #(
  parameter int DEPTH     = 12,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 9,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             dir_tx,
  input  logic [CNT_W-1:0] count,
  input  logic             overflow,
  output logic [7:0]       status,
  output logic             irq
);
  import bytefifo_pkg::*;

  localparam logic [7:0] LOW_C  = 8'(LOW_MARK);
  localparam logic [7:0] HIGH_C = 8'(HIGH_MARK);

  logic [7:0] held;
  logic       low_lvl;
  logic       high_lvl;
  logic       drain_req;
  logic       fill_req;

  assign held      = 8'(count);
  assign low_lvl   = dir_tx && at_or_below(held, LOW_C);
  assign high_lvl  = !dir_tx && at_or_above(held, HIGH_C);
  assign drain_req = dir_tx && (held < LOW_C);
  assign fill_req  = !dir_tx && (held > HIGH_C);

  assign status = {1'b0, high_lvl, low_lvl, overflow, fill_code(held)};
  assign irq    = drain_req || fill_req;

endmodule

// File: rtl/byte_level_fifo.sv
module byte_level_fifo #(
  parameter int DEPTH     = 12,
  parameter int LOW_MARK  = 3,
  parameter int HIGH_MARK = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_tx,
  input  logic       clear_cmd,
  input  logic       host_wr_en,
  input  logic [7:0] host_wr_data,
  input  logic       host_rd_en,
  input  logic       eng_wr_en,
  input  logic [7:0] eng_wr_data,
  input  logic       eng_rd_en,
  output logic [7:0] rd_data,
  output logic [7:0] status,
  output logic       irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push_req;
  logic             pop_req;
  logic [7:0]       push_byte;
  logic             push_ok;
  logic             pop_ok;
  logic             drop;
  logic [CNT_W-1:0] count;
  logic             overflow;
  logic [7:0]       head_data;

  // Direction steering of the two strobe pairs.
  assign push_req  = dir_tx ? host_wr_en   : eng_wr_en;
  assign pop_req   = dir_tx ? eng_rd_en    : host_rd_en;
  assign push_byte = dir_tx ? host_wr_data : eng_wr_data;

  bytefifo_level #(.DEPTH(DEPTH)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear_cmd),
    .push_req (push_req),
    .pop_req  (pop_req),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .drop     (drop),
    .count    (count),
    .overflow (overflow)
  );

  bytefifo_store #(.DEPTH(DEPTH), .WIDTH(8)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear_cmd),
    .push      (push_ok),
    .pop       (pop_ok),
    .wr_data   (push_byte),
    .head_data (head_data)
  );

  bytefifo_flags #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)) u_flags (
    .dir_tx   (dir_tx),
    .count    (count),
    .overflow (overflow),
    .status   (status),
    .irq      (irq)
  );

  assign rd_data = (count == '0) ? 8'h00 : head_data;

endmodule

// File: rtl/byte_level_fifo_chk.sv
module byte_level_fifo_chk #(
  parameter int DEPTH = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_cmd,
  input logic             push_ok,
  input logic             pop_ok,
  input logic             drop,
  input logic [CNT_W-1:0] count,
  input logic             overflow,
  input logic [7:0]       rd_data,
  input logic [7:0]       status,
  input logic             irq
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_C);

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clear_cmd) |=> overflow);

  p_drop_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !clear_cmd) |=> (overflow && $stable(count)));

  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (rd_data == 8'h00));

  p_pushpop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok && !clear_cmd) |=> $stable(count));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_cmd |=> ((count == '0) && !overflow));

  p_irq_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[5] || status[6]));

endmodule

bind byte_level_fifo byte_level_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear_cmd (clear_cmd),
  .push_ok   (push_ok),
  .pop_ok    (pop_ok),
  .drop      (drop),
  .count     (count),
  .overflow  (overflow),
  .rd_data   (rd_data),
  .status    (status),
  .irq       (irq)
);

// File: tb/byte_level_fifo_test.sv
module byte_level_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir_tx = 1'b0;
  logic       clear_cmd = 1'b0;
  logic       host_wr_en = 1'b0;
  logic [7:0] host_wr_data = 8'h00;
  logic       host_rd_en = 1'b0;
  logic       eng_wr_en = 1'b0;
  logic [7:0] eng_wr_data = 8'h00;
  logic       eng_rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [7:0] status;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] mq [SLOTS];
  int  m_head = 0;
  int  m_cnt = 0;
  bit  m_ovf = 0;
  bit  m_tx = 0;

  byte_level_fifo uut (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .clear_cmd(clear_cmd),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .host_rd_en(host_rd_en),
    .eng_wr_en(eng_wr_en), .eng_wr_data(eng_wr_data), .eng_rd_en(eng_rd_en),
    .rd_data(rd_data), .status(status), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_code(input int n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic bit exp_irq(input bit tx, input int n);
    return (tx && n < 3) || (!tx && n > 9);
  endfunction

  task automatic check_outputs();
    int er;
    er = (m_cnt == 0) ? 0 : int'(mq[m_head]);
    check(rd_data == 8'(er), "R2/R5 rd_data", rd_data, er);
    check(status[3:0] == 4'(exp_code(m_cnt)), "R3 fill code", status[3:0], exp_code(m_cnt));
    check(status[4] == m_ovf, "R4 overflow", status[4], m_ovf);
    check(status[5] == (m_tx && m_cnt <= 3), "R7 low flag", status[5], m_tx && m_cnt <= 3);
    check(status[6] == (!m_tx && m_cnt >= 9), "R8 high flag", status[6], !m_tx && m_cnt >= 9);
    check(irq == exp_irq(m_tx, m_cnt), "R9 irq", irq, exp_irq(m_tx, m_cnt));
    check(status[7] == 1'b0, "R12 top bit", status[7], 0);
  endtask

  // One cycle: check current outputs, drive new inputs, advance the model (R10, R11, R6).
  task automatic step(input bit d_tx, input bit clr, input bit hw, input logic [7:0] hd,
                      input bit hr, input bit ew, input logic [7:0] ed, input bit er);
    bit pushr, popr, pok, wok;
    logic [7:0] pb;
    @(negedge clk);
    check_outputs();
    dir_tx = d_tx; clear_cmd = clr; host_wr_en = hw; host_wr_data = hd;
    host_rd_en = hr; eng_wr_en = ew; eng_wr_data = ed; eng_rd_en = er;
    m_tx = d_tx;
    pushr = d_tx ? hw : ew;
    popr  = d_tx ? er : hr;
    pb    = d_tx ? hd : ed;
    if (clr) begin
      m_cnt = 0; m_head = 0; m_ovf = 0;
    end else begin
      pok = popr && (m_cnt > 0);
      wok = pushr && ((m_cnt < SLOTS) || pok);
      if (pushr && !wok) m_ovf = 1;
      if (pok) begin
        m_head = (m_head + 1) % SLOTS;
        m_cnt--;
      end
      if (wok) begin
        mq[(m_head + m_cnt) % SLOTS] = pb;
        m_cnt++;
      end
    end
  endtask

  task automatic idle(input bit d_tx);
    step(d_tx, 0, 0, 8'h00, 0, 0, 8'h00, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    check(status == 8'h00, "R1 status after reset", status, 0);
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);

    // R5: pop on empty in receive direction
    step(0, 0, 0, 8'h00, 1, 0, 8'h00, 0);
    idle(0);

    // R4: transmit direction, fill 12 then one more write
    for (int i = 0; i < 13; i++) step(1, 0, 1, 8'(8'h40 + i), 0, 0, 8'h00, 0);
    idle(1);
    // R6: full, push and pop together
    step(1, 0, 1, 8'hA5, 0, 0, 8'h00, 1);
    idle(1);
    // R11: ignored strobes in transmit direction
    step(1, 0, 0, 8'h00, 1, 1, 8'h77, 0);
    idle(1);
    // R2: drain with wrap
    for (int i = 0; i < 13; i++) step(1, 0, 0, 8'h00, 0, 0, 8'h00, 1);
    idle(1);
    // R4 sticky through drain, then R10 clear colliding with push
    step(1, 1, 1, 8'h33, 0, 0, 8'h00, 0);
    idle(1);
    // R8/R9: receive fill to 11, R11 ignored host write / engine read
    for (int i = 0; i < 11; i++) step(0, 0, 0, 8'h00, 0, 1, 8'(8'h90 + i), 0);
    step(0, 0, 1, 8'h11, 0, 0, 8'h00, 1);
    idle(0);
    // R10: clear with pop pending
    step(0, 1, 0, 8'h00, 1, 0, 8'h00, 0);
    idle(0);

    // Random phases
    for (int ph = 0; ph < 40; ph++) begin
      bit fill = ph[0];
      bit tx = ($urandom % 2) == 1;
      for (int k = 0; k < 40; k++) begin
        int r = $urandom % 100;
        bit wr = fill ? (r < 75) : (r < 25);
        bit rd = fill ? (($urandom % 100) < 25) : (($urandom % 100) < 75);
        bit clr = ($urandom % 200) == 0;
        step(tx, clr,
             tx ? wr : ($urandom % 4 == 0), 8'($urandom),
             tx ? ($urandom % 4 == 0) : rd,
             tx ? ($urandom % 4 == 0) : wr, 8'($urandom),
             tx ? rd : ($urandom % 4 == 0));
      end
    end
    idle(0);
    @(negedge clk);
    check_outputs();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule